// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Queue

The block watches a stream of inbound memory writes (64-bit address, 32-bit data, one-cycle valid) and keeps every write that lands inside a programmed doorbell region. Each captured write is queued as one entry, holding the data word and the full address. Software drains the queue through a 32-bit register bus. For each entry it reads the data word and both halves of the address. The entry leaves the queue only after all three of those reads have been made.

Software sets up the region with a 64-bit base, split into a low and a high word, and a 32-bit byte length, then sets the enable bit. A typical setup uses a 4096-byte region in which vector n writes data n to base + 4*n, for 16 vectors. A status register reports whether anything is pending and whether a write was lost because the queue was full. The pending level is also driven out on a pin that feeds the interrupt aggregator.

Top module: `msi_capture`

## Requirements
- R1: After reset the queue is empty, `msi_pending` is 0, and the status, base-low, base-high, size and enable registers all read 0.
- R2: The register offsets are fixed as follows: base low 0x04, base high 0x08, size 0x0C, enable 0x14 (bit 0), status 0x18, head data 0x20, head address low 0x24, head address high 0x28. Each configuration register reads back the value last written to it.
- R3: An inbound write is queued only while enable bit 0 is 1. While enable is 0, a write is discarded even if its address lies inside the region.
- R4: Entries leave the queue in arrival order. Each one returns exactly the data word and both 32-bit halves of the address of the write that created it.
- R5: Status bit 0 is 1 exactly while at least one entry is queued. `msi_pending` always equals status bit 0.
- R6: The head entry is removed on the read that completes the set {data, address low, address high}. The three reads may come in any order. A repeated read of a register already counted for the current entry does not advance the removal.
- R7: The queue holds DEPTH entries (default 16). A qualifying write that arrives while the queue is full is dropped and sets status bit 1. Bit 1 stays set until software writes 1 to status bit 1.
- R8: While the queue is empty, reads of the data and address registers return 0 and are not counted toward removing a later entry.
- R9: A write qualifies only when base <= address < base + size, compared as 64-bit values. The byte at base is inside the region and the byte at base + size is outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd_en` |
| msi_valid | input | 1 | Inbound memory write present this cycle |
| msi_addr | input | 64 | Inbound write address |
| msi_data | input | 32 | Inbound write data |
| msi_pending | output | 1 | High while the queue holds an entry |

## Verification
On every cycle, the assertions check the following properties:
- a disabled block never queues a write;
- a write that hits a full queue raises the overflow flag, and the flag holds until it is cleared;
- the queue never removes an entry from an empty queue, and never exceeds its depth;
- a push into an otherwise idle queue leaves it non-empty.

Other behaviours can only be shown by the bench's scenarios:
- arrival ordering of entries;
- the exact edges of the address region;
- removal of an entry after three reads made in any order;
- repeated reads not being counted twice;
- reads made on an empty queue being ignored.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFF_BASE_LO = 8'h04;
  localparam logic [REG_AW-1:0] OFF_BASE_HI = 8'h08;
  localparam logic [REG_AW-1:0] OFF_SIZE    = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_ENABLE  = 8'h14;
  localparam logic [REG_AW-1:0] OFF_STATUS  = 8'h18;
  localparam logic [REG_AW-1:0] OFF_DATA    = 8'h20;
  localparam logic [REG_AW-1:0] OFF_ADDR_LO = 8'h24;
  localparam logic [REG_AW-1:0] OFF_ADDR_HI = 8'h28;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msi_entry_t;

  localparam int ENTRY_W = $bits(msi_entry_t);
endpackage

// File: rtl/msi_cap_window.sv
module msi_cap_window #(
  parameter int AW = 64,
  parameter int SW = 32
) (
  input  logic          valid,
  input  logic          enable,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] offset;
  logic          above_base;
  logic          below_end;

  always_comb begin
    offset     = addr - base;
    above_base = (addr >= base);
    below_end  = (offset < AW'(size));
    hit        = valid && enable && above_base && below_end;
  end
endmodule

// File: rtl/msi_cap_fifo.sv
module msi_cap_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 96
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_push_fills_R5: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/msi_cap_drain.sv
module msi_cap_drain (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_stb,
  input  logic [2:0] rd_sel,
  input  logic       empty,
  output logic       pop
);
  logic [2:0] seen_q;
  logic [2:0] seen_nxt;
  logic       counted;

  always_comb begin
    counted  = rd_stb && !empty && (rd_sel != 3'b000);
    seen_nxt = seen_q | rd_sel;
    pop      = counted && (seen_nxt == 3'b111);
  end

  always_ff @(posedge clk) begin
    if (rst)          seen_q <= '0;
    else if (pop)     seen_q <= '0;
    else if (counted) seen_q <= seen_nxt;
  end

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_cap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        msi_valid,
  input  logic [63:0] msi_addr,
  input  logic [31:0] msi_data,
  output logic        msi_pending
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [31:0] base_lo_q, base_hi_q, size_q;
  logic        enable_q, ovf_q;
  logic [31:0] rdata_q;

  logic        win_hit;
  logic        fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_count;
  msi_entry_t  head, wr_entry;
  logic [2:0]  rd_sel;
  logic        ovf_clr;

  msi_cap_window #(.AW(64), .SW(32)) u_win (
    .valid  (msi_valid),
    .enable (enable_q),
    .base   ({base_hi_q, base_lo_q}),
    .size   (size_q),
    .addr   (msi_addr),
    .hit    (win_hit)
  );

  always_comb begin
    wr_entry.addr = msi_addr;
    wr_entry.data = msi_data;
    fifo_push     = win_hit && !fifo_full;
  end

  msi_cap_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .wdata (wr_entry),
    .pop   (fifo_pop),
    .head  (head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_count)
  );

  always_comb begin
    rd_sel = 3'b000;
    if (reg_rd_en) begin
      case (reg_addr)
        OFF_DATA:    rd_sel = 3'b001;
        OFF_ADDR_LO: rd_sel = 3'b010;
        OFF_ADDR_HI: rd_sel = 3'b100;
        default:     rd_sel = 3'b000;
      endcase
    end
  end

  msi_cap_drain u_drain (
    .clk    (clk),
    .rst    (rst),
    .rd_stb (reg_rd_en),
    .rd_sel (rd_sel),
    .empty  (fifo_empty),
    .pop    (fifo_pop)
  );

  assign ovf_clr = reg_wr_en && (reg_addr == OFF_STATUS) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      size_q    <= '0;
      enable_q  <= 1'b0;
      ovf_q     <= 1'b0;
    end else begin
      if (reg_wr_en) begin
        case (reg_addr)
          OFF_BASE_LO: base_lo_q <= reg_wdata;
          OFF_BASE_HI: base_hi_q <= reg_wdata;
          OFF_SIZE:    size_q    <= reg_wdata;
          OFF_ENABLE:  enable_q  <= reg_wdata[0];
          default: ;
        endcase
      end
      if (win_hit && fifo_full) ovf_q <= 1'b1;
      else if (ovf_clr)         ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      case (reg_addr)
        OFF_BASE_LO: rdata_q <= base_lo_q;
        OFF_BASE_HI: rdata_q <= base_hi_q;
        OFF_SIZE:    rdata_q <= size_q;
        OFF_ENABLE:  rdata_q <= {31'b0, enable_q};
        OFF_STATUS:  rdata_q <= {30'b0, ovf_q, !fifo_empty};
        OFF_DATA:    rdata_q <= fifo_empty ? 32'h0 : head.data;
        OFF_ADDR_LO: rdata_q <= fifo_empty ? 32'h0 : head.addr[31:0];
        OFF_ADDR_HI: rdata_q <= fifo_empty ? 32'h0 : head.addr[63:32];
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata   = rdata_q;
  assign msi_pending = !fifo_empty;

  assert_capture_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !enable_q |-> !fifo_push);
  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (win_hit && fifo_full) |=> ovf_q);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_count_hidden_R1: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0) |-> !msi_pending);
endmodule

// File: tb/sim_msi_capture.sv
module sim_msi_capture;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic        msi_pending;

  int total = 0;
  int bad   = 0;
  int wd    = 0;
  bit done  = 1'b0;

  localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;
  // {expect_queued, address, data}
  localparam int NV = 8;
  localparam logic [96:0] VEC [NV] = '{
    {1'b1, BASE,                        32'd0},
    {1'b1, BASE + 64'd20,               32'd5},
    {1'b1, BASE + 64'h3C,               32'd15},
    {1'b0, BASE + 64'h1000,             32'd99},
    {1'b0, BASE - 64'd4,                32'd98},
    {1'b0, 64'h0000_0002_8000_0000,     32'd97},
    {1'b1, BASE + 64'hFFC,              32'h0000_ABCD},
    {1'b1, BASE + 64'd8,                32'd2}
  };

  logic [63:0] m_addr [32];
  logic [31:0] m_data [32];
  int m_n = 0;

  msi_capture u0 (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
    .msi_pending(msi_pending)
  );

  always #10 clk = ~clk;

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  // drain one entry; order 0: d,l,h  1: h,d,l  2: l,h,d
  task automatic drain_one(int order, logic [63:0] ea, logic [31:0] ed);
    logic [31:0] v;
    for (int s = 0; s < 3; s++) begin
      int which;
      which = (s + (order == 1 ? 2 : (order == 2 ? 1 : 0))) % 3;
      case (which)
        0: begin rd(8'h20, v); check("R4 data", v, ed); end
        1: begin rd(8'h24, v); check("R4 addr_lo", v, ea[31:0]); end
        default: begin rd(8'h28, v); check("R4 addr_hi", v, ea[63:32]); end
      endcase
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pending", msi_pending, 0);
    rd(8'h18, v); check("R1 status", v, 0);
    rd(8'h04, v); check("R1 base_lo", v, 0);
    rd(8'h08, v); check("R1 base_hi", v, 0);
    rd(8'h0C, v); check("R1 size", v, 0);
    rd(8'h14, v); check("R1 enable", v, 0);

    // R2 programming and readback
    wr(8'h04, BASE[31:0]); wr(8'h08, BASE[63:32]); wr(8'h0C, 32'd4096);
    rd(8'h04, v); check("R2 base_lo", v, BASE[31:0]);
    rd(8'h08, v); check("R2 base_hi", v, BASE[63:32]);
    rd(8'h0C, v); check("R2 size", v, 32'd4096);

    // R3 disabled: in-window write discarded
    send(BASE + 64'd4, 32'd1);
    rd(8'h18, v); check("R3 disabled drop", v, 0);
    check("R3 pending", msi_pending, 0);
    wr(8'h14, 32'd1);
    rd(8'h14, v); check("R2 enable", v, 1);

    // Vector table: R3/R9 filtering, model records queued ones
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][95:32], VEC[i][31:0]);
      if (VEC[i][96]) begin
        m_addr[m_n] = VEC[i][95:32]; m_data[m_n] = VEC[i][31:0]; m_n++;
      end
    end
    rd(8'h18, v); check("R5 status nonempty", v, 1);
    check("R5 pending", msi_pending, 1);

    // R4/R6/R9 drain in varying orders; filtered entries must not appear
    for (int i = 0; i < m_n; i++) begin
      drain_one(i % 3, m_addr[i], m_data[i]);
    end
    rd(8'h18, v); check("R9 R5 status empty after drain", v, 0);
    check("R5 pending low", msi_pending, 0);

    // R6 repeated reads do not count twice
    send(BASE + 64'd12, 32'd3);
    rd(8'h20, v); rd(8'h20, v); rd(8'h24, v); rd(8'h24, v);
    rd(8'h18, v); check("R6 still queued", v, 1);
    rd(8'h28, v); check("R6 addr_hi", v, BASE[63:32]);
    rd(8'h18, v); check("R6 popped", v, 0);

    // R8 empty reads return 0 and are not counted
    rd(8'h24, v); check("R8 empty lo", v, 0);
    rd(8'h28, v); check("R8 empty hi", v, 0);
    rd(8'h20, v); check("R8 empty data", v, 0);
    send(BASE + 64'd16, 32'd4);
    rd(8'h20, v); check("R8 data", v, 4);
    rd(8'h18, v); check("R8 not popped by earlier reads", v, 1);
    rd(8'h24, v); rd(8'h28, v);
    rd(8'h18, v); check("R8 popped", v, 0);

    // R7 overflow
    for (int i = 0; i < 17; i++) send(BASE + 64'(4 * (i % 16)), 32'(100 + i));
    rd(8'h18, v); check("R7 overflow flag", v, 3);
    for (int i = 0; i < 16; i++) drain_one(0, BASE + 64'(4 * (i % 16)), 32'(100 + i));
    rd(8'h18, v); check("R7 17th dropped, flag sticky", v, 2);
    wr(8'h18, 32'd2);
    rd(8'h18, v); check("R7 flag cleared", v, 0);

    // R9 region edge with a small size
    wr(8'h0C, 32'h10);
    send(BASE + 64'h10, 32'd7);
    rd(8'h18, v); check("R9 end excluded", v, 0);
    send(BASE + 64'hC, 32'd8);
    drain_one(2, BASE + 64'hC, 32'd8);
    rd(8'h18, v); check("R9 last byte range drained", v, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule